// File: doc/BRIEF.md
# Dual-Port Address Contention Arbiter

This block sits beside a two-ported storage array and decides which port may write when both ports reach the same word at the same time. Each side presents an enable, a write strobe and an address on every clock. The arbiter samples these requests at the clock edge. One cycle later it reports, for the sampled request, a busy flag, a write permit and a read permit for each side. The storage array itself lies outside the block.

A mode input picks one of two roles. As a master, the arbiter compares the two sampled addresses and keeps a small ownership state machine. It drives a busy flag to the losing side and withholds that side's write permit. As a slave, it holds its own busy outputs low and takes busy flags from a master device through two inputs. It gates its write permits with those flags and ignores its own comparison. Several arbiters can therefore run side by side to form a wider word, all following one master's decisions with no glue logic.

The state machine has three states: `ARB_FREE` (no contention), `ARB_LEFT_HOLDS` (left owns the shared word, so right is busy) and `ARB_RIGHT_HOLDS` (right owns it, so left is busy). It has four named transitions. `T_RELEASE` goes to `ARB_FREE` when the new requests no longer collide. `T_KEEP` keeps the current owner while that owner stays on the same word. `T_CLAIM_LEFT` and `T_CLAIM_RIGHT` settle a new collision in favour of whichever side was already on that word in the previous cycle, or in favour of left if neither or both were.

Top module: `dpa_contention_arbiter`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, all busy outputs and all write and read permits are 0.
- R2: When the two sampled requests do not collide, neither side is busy, and each side's write permit equals enable AND write strobe of its sampled request.
- R3: A collision is both sampled enables high with equal addresses. In a collision that neither side held in the previous cycle, left wins: in master mode busy_r_o is 1 and busy_l_o is 0 for that sampled request.
- R4: In a new collision where right was enabled at that address in the previous cycle and left was not, right wins: busy_l_o is 1 and busy_r_o is 0.
- R5: Once a side owns a collision, it keeps ownership for as long as the collision persists and its own address stays unchanged.
- R6: When only one side is enabled, no busy flag is raised, whatever the addresses are.
- R7: Busy drops in the cycle after the requests stop colliding, whether because the addresses differ or because either enable goes low.
- R8: A busy side gets a write permit of 0. Its read permit (enable high, write strobe low) is still granted.
- R9: In slave mode (master_i = 0), busy_l_o and busy_r_o stay 0. Each write permit is additionally gated by that side's external busy input.
- R10: In slave mode the block's own address comparison has no effect: two colliding writes with both external busy inputs low both receive write permits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| master_i | input | 1 | 1 = master (busy computed locally), 0 = slave (busy taken from inputs) |
| en_l_i | input | 1 | Left request enable |
| we_l_i | input | 1 | Left write strobe (1 = write, 0 = read) |
| addr_l_i | input | ADDR_W | Left word address |
| en_r_i | input | 1 | Right request enable |
| we_r_i | input | 1 | Right write strobe |
| addr_r_i | input | ADDR_W | Right word address |
| busy_l_i | input | 1 | External busy for left, used in slave mode |
| busy_r_i | input | 1 | External busy for right, used in slave mode |
| busy_l_o | output | 1 | Left busy flag, master mode only |
| busy_r_o | output | 1 | Right busy flag, master mode only |
| wr_ok_l_o | output | 1 | Left write permit for the sampled request |
| wr_ok_r_o | output | 1 | Right write permit for the sampled request |
| rd_ok_l_o | output | 1 | Left read permit for the sampled request |
| rd_ok_r_o | output | 1 | Right read permit for the sampled request |

## Verification
The bench aims at the ownership corner cases.

- A simultaneous fresh collision must go to left. A design that favours right, or flags both sides, gives the wrong busy side.
- A late-arriving left side must lose to an incumbent right. A design without history would give that collision to left.
- An owner that stays put must keep the word. A design that re-settles every cycle would toggle ownership.
- Busy must clear exactly one cycle after the requests separate. A stuck flag or an early release shows up as a wrong flag in that cycle.

Slave mode gets a collision with both external busy inputs low. A design that still used its local comparison would withhold a write permit or drive a busy output. Random traffic on a four-word window then mixes both modes against a reference model in the bench.

// File: rtl/dpa_pkg.sv
package dpa_pkg;
    typedef enum logic [1:0] {
        ARB_FREE        = 2'd0,
        ARB_LEFT_HOLDS  = 2'd1,
        ARB_RIGHT_HOLDS = 2'd2
    } arb_state_e;

    localparam int PORT_L = 0;
    localparam int PORT_R = 1;
    localparam int NUM_PORTS = 2;
endpackage

// File: rtl/dpa_req_reg.sv
module dpa_req_reg #(
    parameter int ADDR_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              en_q,
    output logic              we_q,
    output logic [ADDR_W-1:0] addr_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            we_q   <= 1'b0;
            addr_q <= '0;
        end else begin
            en_q   <= en_i;
            we_q   <= we_i;
            addr_q <= addr_i;
        end
    end
endmodule

// File: rtl/dpa_arb_fsm.sv
module dpa_arb_fsm
    import dpa_pkg::*;
#(
    parameter int ADDR_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_l_i,
    input  logic [ADDR_W-1:0] addr_l_i,
    input  logic              en_r_i,
    input  logic [ADDR_W-1:0] addr_r_i,
    input  logic              en_l_q,
    input  logic [ADDR_W-1:0] addr_l_q,
    input  logic              en_r_q,
    input  logic [ADDR_W-1:0] addr_r_q,
    output logic              left_blocked_o,
    output logic              right_blocked_o
);
    arb_state_e state_q, state_d;
    logic       hit, left_held, right_held;
    arb_state_e fresh_owner;

    always_comb begin
        hit         = en_l_i && en_r_i && (addr_l_i == addr_r_i);
        left_held   = en_l_q && (addr_l_q == addr_l_i);
        right_held  = en_r_q && (addr_r_q == addr_r_i);
        // T_CLAIM_RIGHT only for a sole incumbent right; otherwise T_CLAIM_LEFT
        fresh_owner = (right_held && !left_held) ? ARB_RIGHT_HOLDS : ARB_LEFT_HOLDS;
        state_d     = ARB_FREE;
        unique case (state_q)
            ARB_FREE: begin
                state_d = hit ? fresh_owner : ARB_FREE;
            end
            ARB_LEFT_HOLDS: begin
                if (!hit)                        state_d = ARB_FREE;        // T_RELEASE
                else if (addr_l_i == addr_l_q)   state_d = ARB_LEFT_HOLDS;  // T_KEEP
                else                             state_d = fresh_owner;
            end
            ARB_RIGHT_HOLDS: begin
                if (!hit)                        state_d = ARB_FREE;        // T_RELEASE
                else if (addr_r_i == addr_r_q)   state_d = ARB_RIGHT_HOLDS; // T_KEEP
                else                             state_d = fresh_owner;
            end
            default: state_d = ARB_FREE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ARB_FREE;
        else        state_q <= state_d;
    end

    always_comb begin
        left_blocked_o  = 1'b0;
        right_blocked_o = 1'b0;
        unique case (state_q)
            ARB_FREE:        ;
            ARB_LEFT_HOLDS:  right_blocked_o = 1'b1;
            ARB_RIGHT_HOLDS: left_blocked_o  = 1'b1;
            default:         ;
        endcase
    end

    // R6: ownership only exists for two enabled requests on one word
    p_hold_needs_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ARB_FREE) |-> (en_l_q && en_r_q && (addr_l_q == addr_r_q)));
endmodule

// File: rtl/dpa_permit.sv
module dpa_permit (
    input  logic clk,
    input  logic rst_n,
    input  logic master_i,
    input  logic left_blocked_i,
    input  logic right_blocked_i,
    input  logic busy_l_i,
    input  logic busy_r_i,
    input  logic en_l_q,
    input  logic we_l_q,
    input  logic en_r_q,
    input  logic we_r_q,
    output logic busy_l_o,
    output logic busy_r_o,
    output logic wr_ok_l_o,
    output logic wr_ok_r_o,
    output logic rd_ok_l_o,
    output logic rd_ok_r_o
);
    logic stop_l, stop_r;

    always_comb begin
        stop_l    = master_i ? left_blocked_i  : busy_l_i;
        stop_r    = master_i ? right_blocked_i : busy_r_i;
        busy_l_o  = master_i && left_blocked_i;
        busy_r_o  = master_i && right_blocked_i;
        wr_ok_l_o = en_l_q && we_l_q && !stop_l;
        wr_ok_r_o = en_r_q && we_r_q && !stop_r;
        rd_ok_l_o = en_l_q && !we_l_q;
        rd_ok_r_o = en_r_q && !we_r_q;
    end

    p_busy_no_write_l_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stop_l |-> !wr_ok_l_o);
    p_busy_no_write_r_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stop_r |-> !wr_ok_r_o);
    p_slave_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !master_i |-> (!busy_l_o && !busy_r_o));
endmodule

// File: rtl/dpa_contention_arbiter.sv
module dpa_contention_arbiter
    import dpa_pkg::*;
#(
    parameter int ADDR_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              master_i,
    input  logic              en_l_i,
    input  logic              we_l_i,
    input  logic [ADDR_W-1:0] addr_l_i,
    input  logic              en_r_i,
    input  logic              we_r_i,
    input  logic [ADDR_W-1:0] addr_r_i,
    input  logic              busy_l_i,
    input  logic              busy_r_i,
    output logic              busy_l_o,
    output logic              busy_r_o,
    output logic              wr_ok_l_o,
    output logic              wr_ok_r_o,
    output logic              rd_ok_l_o,
    output logic              rd_ok_r_o
);
    logic [NUM_PORTS-1:0] en_in, we_in, en_q, we_q;
    logic [ADDR_W-1:0]    addr_in [NUM_PORTS];
    logic [ADDR_W-1:0]    addr_q  [NUM_PORTS];
    logic                 left_blocked, right_blocked;

    assign en_in[PORT_L]   = en_l_i;
    assign en_in[PORT_R]   = en_r_i;
    assign we_in[PORT_L]   = we_l_i;
    assign we_in[PORT_R]   = we_r_i;
    assign addr_in[PORT_L] = addr_l_i;
    assign addr_in[PORT_R] = addr_r_i;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_req
        dpa_req_reg #(.ADDR_W(ADDR_W)) req_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .en_i   (en_in[p]),
            .we_i   (we_in[p]),
            .addr_i (addr_in[p]),
            .en_q   (en_q[p]),
            .we_q   (we_q[p]),
            .addr_q (addr_q[p])
        );
    end

    dpa_arb_fsm #(.ADDR_W(ADDR_W)) fsm_i (
        .clk             (clk),
        .rst_n           (rst_n),
        .en_l_i          (en_l_i),
        .addr_l_i        (addr_l_i),
        .en_r_i          (en_r_i),
        .addr_r_i        (addr_r_i),
        .en_l_q          (en_q[PORT_L]),
        .addr_l_q        (addr_q[PORT_L]),
        .en_r_q          (en_q[PORT_R]),
        .addr_r_q        (addr_q[PORT_R]),
        .left_blocked_o  (left_blocked),
        .right_blocked_o (right_blocked)
    );

    dpa_permit permit_i (
        .clk             (clk),
        .rst_n           (rst_n),
        .master_i        (master_i),
        .left_blocked_i  (left_blocked),
        .right_blocked_i (right_blocked),
        .busy_l_i        (busy_l_i),
        .busy_r_i        (busy_r_i),
        .en_l_q          (en_q[PORT_L]),
        .we_l_q          (we_q[PORT_L]),
        .en_r_q          (en_q[PORT_R]),
        .we_r_q          (we_q[PORT_R]),
        .busy_l_o        (busy_l_o),
        .busy_r_o        (busy_r_o),
        .wr_ok_l_o       (wr_ok_l_o),
        .wr_ok_r_o       (wr_ok_r_o),
        .rd_ok_l_o       (rd_ok_l_o),
        .rd_ok_r_o       (rd_ok_r_o)
    );

    // R7: a request pair that does not collide leaves no busy flag next cycle
    p_split_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(en_l_i && en_r_i && (addr_l_i == addr_r_i)) |=> (!busy_l_o && !busy_r_o));
    // R5: an owning left side that stays on its word keeps the right side busy
    p_owner_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_r_o && en_l_i && en_r_i && (addr_l_i == addr_r_i)
         && (addr_l_i == addr_q[PORT_L])) |=> (!master_i || busy_r_o));
    // R3/R4: the two busy flags never rise together
    p_single_loser_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_l_o && busy_r_o));
endmodule

// File: tb/dpa_contention_arbiter_tb_top.sv
`timescale 1ns/1ps
module dpa_contention_arbiter_tb_top;
    localparam int AW = 14;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic master_i = 1'b1;
    logic en_l_i = 0, we_l_i = 0, en_r_i = 0, we_r_i = 0;
    logic [AW-1:0] addr_l_i = '0, addr_r_i = '0;
    logic busy_l_i = 0, busy_r_i = 0;
    logic busy_l_o, busy_r_o, wr_ok_l_o, wr_ok_r_o, rd_ok_l_o, rd_ok_r_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // bench reference: 0 free, 1 left owns, 2 right owns
    int m_st = 0;
    bit q_el = 0, q_wl = 0, q_er = 0, q_wr = 0;
    logic [AW-1:0] q_al = '0, q_ar = '0;

    always #2.5 clk = ~clk;

    dpa_contention_arbiter #(.ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .master_i(master_i),
        .en_l_i(en_l_i), .we_l_i(we_l_i), .addr_l_i(addr_l_i),
        .en_r_i(en_r_i), .we_r_i(we_r_i), .addr_r_i(addr_r_i),
        .busy_l_i(busy_l_i), .busy_r_i(busy_r_i),
        .busy_l_o(busy_l_o), .busy_r_o(busy_r_o),
        .wr_ok_l_o(wr_ok_l_o), .wr_ok_r_o(wr_ok_r_o),
        .rd_ok_l_o(rd_ok_l_o), .rd_ok_r_o(rd_ok_r_o)
    );

    function automatic int next_owner(int st, bit el, logic [AW-1:0] al, bit er,
                                      logic [AW-1:0] ar);
        bit collide = el && er && (al == ar);
        bit lh = q_el && (q_al == al);
        bit rh = q_er && (q_ar == ar);
        if (!collide) return 0;
        if (st == 1 && al == q_al) return 1;
        if (st == 2 && ar == q_ar) return 2;
        return (rh && !lh) ? 2 : 1;
    endfunction

    task automatic cmp(string tag, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
        end
    endtask

    task automatic check_all(string tag);
        bit sl = master_i ? (m_st == 2) : busy_l_i;
        bit sr = master_i ? (m_st == 1) : busy_r_i;
        cmp(tag, "busy_l_o", busy_l_o, master_i && m_st == 2);
        cmp(tag, "busy_r_o", busy_r_o, master_i && m_st == 1);
        cmp(tag, "wr_ok_l_o", wr_ok_l_o, q_el && q_wl && !sl);
        cmp(tag, "wr_ok_r_o", wr_ok_r_o, q_er && q_wr && !sr);
        cmp(tag, "rd_ok_l_o", rd_ok_l_o, q_el && !q_wl);
        cmp(tag, "rd_ok_r_o", rd_ok_r_o, q_er && !q_wr);
    endtask

    // drive at a falling edge, pass one rising edge, check at the next falling edge
    task automatic step(bit el, bit wl, logic [AW-1:0] al, bit er, bit wr,
                        logic [AW-1:0] ar, bit ms, bit bl, bit br, string tag);
        en_l_i = el; we_l_i = wl; addr_l_i = al;
        en_r_i = er; we_r_i = wr; addr_r_i = ar;
        master_i = ms; busy_l_i = bl; busy_r_i = br;
        m_st = next_owner(m_st, el, al, er, ar);
        q_el = el; q_wl = wl; q_al = al; q_er = er; q_wr = wr; q_ar = ar;
        @(negedge clk);
        check_all(tag);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1: outputs quiet in reset
        check_all("R1");
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1");

        // R2: different words, both writes granted
        step(1,1,14'd1, 1,1,14'd2, 1,0,0, "R2");
        // R3: fresh simultaneous collision goes to left; R8 right write blocked
        step(1,1,14'd5, 1,1,14'd5, 1,0,0, "R3");
        cmp("R3", "right busy", busy_r_o, 1'b1);
        cmp("R8", "right write blocked", wr_ok_r_o, 1'b0);
        // R7: separate, busy clears in the next cycle
        step(1,1,14'd5, 1,1,14'd6, 1,0,0, "R7");
        cmp("R7", "right busy cleared", busy_r_o, 1'b0);
        // R4: right incumbent, left arrives later
        step(0,0,14'd0, 1,1,14'd7, 1,0,0, "R4");
        step(1,1,14'd7, 1,1,14'd7, 1,0,0, "R4");
        cmp("R4", "left busy", busy_l_o, 1'b1);
        // R5: owner stays, ownership kept; R8 busy left may still read
        step(1,0,14'd7, 1,1,14'd7, 1,0,0, "R5");
        cmp("R5", "left still busy", busy_l_o, 1'b1);
        cmp("R8", "busy left read granted", rd_ok_l_o, 1'b1);
        // R7: enable drop clears busy
        step(1,1,14'd7, 0,1,14'd7, 1,0,0, "R7");
        cmp("R7", "left busy cleared", busy_l_o, 1'b0);
        // R6: one side disabled on the same word
        step(1,1,14'd9, 0,1,14'd9, 1,0,0, "R6");
        cmp("R6", "no busy single enable", busy_l_o | busy_r_o, 1'b0);
        // R10: slave mode collision, external busy low, both write
        step(1,1,14'd3, 1,1,14'd3, 0,0,0, "R10");
        cmp("R10", "slave left write", wr_ok_l_o, 1'b1);
        cmp("R10", "slave right write", wr_ok_r_o, 1'b1);
        // R9: external busy blocks write, busy outputs stay low
        step(1,1,14'd3, 1,1,14'd3, 0,1,0, "R9");
        cmp("R9", "slave left blocked", wr_ok_l_o, 1'b0);
        cmp("R9", "slave busy_l_o low", busy_l_o, 1'b0);

        // random traffic on a narrow window, mostly master mode
        for (int i = 0; i < 3000; i++) begin
            bit el = ($urandom % 4) != 0;
            bit er = ($urandom % 4) != 0;
            logic [AW-1:0] al = AW'($urandom % 4);
            logic [AW-1:0] ar = AW'($urandom % 4);
            bit wl = $urandom % 2;
            bit wr = $urandom % 2;
            bit ms = ($urandom % 5) != 0;
            bit bl = ($urandom % 4) == 0;
            bit br = ($urandom % 4) == 0;
            step(el, wl, al, er, wr, ar, ms, bl, br, "R2/R3/R4/R5/R6/R7/R8/R9");
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(5 * 20000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule